// File: doc/BRIEF.md
# Stepped Scan Shift Rate Controller

This block sits between an activity monitor and the scan chains of a design under test. It runs from a free-running fast clock and produces a one-cycle shift-enable tick. The tick repeats at one of `NUM_RATES` discrete rates. A rate index selects the divide ratio. Index 0 is the slowest rate, which divides by `NUM_RATES`. The top index is the fastest rate, which ticks on every fast-clock cycle. In general, index k divides by `NUM_RATES - k`.

The activity monitor sends single-cycle speed-up and slow-down requests. Each accepted request moves a pending index by one step, and the index saturates at both ends. The pending index becomes the index in use only when the current tick interval ends, so a shift period is never cut short. Every step that actually changes the index is echoed on an output pin one cycle later, which lets the external tester follow the shift rate.

A scan-start strobe begins each scan-in. It restarts the divider and loads the slowest index. If a preset-valid flag is raised with the strobe, it loads a supplied starting index instead. That preset carries the starting rate that stored test data has computed for the next pattern.

Top module: `scan_rate_ctrl`

## Requirements
- R1: While reset is asserted, and just after it is released, rateIdx is 0, divRatio equals NUM_RATES, and shiftTick, speedUpOut and slowDownOut are all low.
- R2: With the index in use equal to k, shiftTick goes high for one cycle once every NUM_RATES−k fast-clock cycles, and divRatio reads NUM_RATES−k.
- R3: Each cycle in which speedUp alone is high raises the pending index by one. Each cycle in which slowDown alone is high lowers it by one.
- R4: A change of the pending index reaches rateIdx and divRatio only on the clock edge that ends a tick interval. The interval in progress keeps its full length.
- R5: The index never rises above NUM_RATES−1 and never falls below 0, whatever requests arrive.
- R6: When speedUp and slowDown are high in the same cycle, the index does not change.
- R7: When scanStart is high with presetValid low, the next edge sets rateIdx to 0 and restarts the divider. The first tick then follows NUM_RATES cycles after the edge on which scanStart is sampled.
- R8: When scanStart and presetValid are both high, presetIdx is loaded as the index. Any value above NUM_RATES−1 is clamped to NUM_RATES−1. The first tick then follows NUM_RATES−k cycles after the start edge.
- R9: speedUpOut or slowDownOut is high for exactly one cycle after a request that changed the pending index. Both stay low after a saturated, cancelled or start-cycle request.
- R10: A scanStart in the same cycle as a step request takes priority. The request is dropped and is not echoed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running fastest clock |
| rstN | input | 1 | Active-low synchronous reset |
| scanStart | input | 1 | One-cycle strobe at the start of a scan-in |
| presetValid | input | 1 | With scanStart, load presetIdx instead of the slowest index |
| presetIdx | input | IDX_W | Starting rate index from stored test data |
| speedUp | input | 1 | Step request toward a faster rate |
| slowDown | input | 1 | Step request toward a slower rate |
| shiftTick | output | 1 | One-cycle shift enable at the chosen rate |
| rateIdx | output | IDX_W | Rate index currently in use |
| divRatio | output | CNT_W | Divide ratio currently in use |
| speedUpOut | output | 1 | Echo of an accepted speed-up step, to the tester |
| slowDownOut | output | 1 | Echo of an accepted slow-down step, to the tester |

## Verification
A wrong pending index stays hidden until the next tick boundary. It then shows up on rateIdx and divRatio, and on every later tick interval. For that reason the bench measures interval lengths both before and after each boundary.

A faulty divider counter shows up within one interval, as a tick that comes early or late. A bad echo or a bad saturation test shows on the echo pins in the very next cycle. The start tests count cycles from the start edge, so a divider that is not restarted gives a wrong first interval.

// File: rtl/scan_rate_pkg.sv
package scan_rate_pkg;

  // Strobes from the rate control to the divider datapath.
  typedef struct packed {
    logic restart;   // begin a fresh interval from phase zero
  } divStrobes_t;

endpackage

// File: rtl/rate_step_ctrl.sv
module rate_step_ctrl
  import scan_rate_pkg::*;
#(
  parameter int NUM_RATES = 6,
  localparam int IDX_W = $clog2(NUM_RATES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             scanStart,
  input  logic             presetValid,
  input  logic [IDX_W-1:0] presetIdx,
  input  logic             speedUp,
  input  logic             slowDown,
  input  logic             tick,
  output logic [IDX_W-1:0] activeIdx,
  output logic             upEcho,
  output logic             downEcho,
  output divStrobes_t      strobes
);

  localparam logic [IDX_W-1:0] MAX_IDX = IDX_W'(NUM_RATES - 1);

  logic [IDX_W-1:0] pendingIdx;
  logic [IDX_W-1:0] pendingNext;
  logic [IDX_W-1:0] startIdx;
  logic             upOnly;
  logic             downOnly;
  logic             stepUp;
  logic             stepDown;

  always_comb begin
    upOnly   = speedUp & ~slowDown;
    downOnly = slowDown & ~speedUp;
    stepUp   = upOnly & ~scanStart & (pendingIdx != MAX_IDX);
    stepDown = downOnly & ~scanStart & (pendingIdx != '0);
    if (stepUp)
      pendingNext = pendingIdx + 1'b1;
    else if (stepDown)
      pendingNext = pendingIdx - 1'b1;
    else
      pendingNext = pendingIdx;
    if (!presetValid)
      startIdx = '0;
    else if (presetIdx > MAX_IDX)
      startIdx = MAX_IDX;
    else
      startIdx = presetIdx;
    strobes.restart = scanStart;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendingIdx <= '0;
      activeIdx  <= '0;
      upEcho     <= 1'b0;
      downEcho   <= 1'b0;
    end else if (scanStart) begin
      pendingIdx <= startIdx;
      activeIdx  <= startIdx;
      upEcho     <= 1'b0;
      downEcho   <= 1'b0;
    end else begin
      pendingIdx <= pendingNext;
      if (tick)
        activeIdx <= pendingNext;
      upEcho   <= stepUp;
      downEcho <= stepDown;
    end
  end

  assert_idx_bounded_R5: assert property (@(posedge clk) disable iff (!rstN)
    (pendingIdx <= MAX_IDX) && (activeIdx <= MAX_IDX));

  assert_hold_between_ticks_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !scanStart) |=> $stable(activeIdx));

  assert_up_echo_step_R9: assert property (@(posedge clk) disable iff (!rstN)
    upEcho |-> (pendingIdx == $past(pendingIdx) + 1'b1));

  assert_down_echo_step_R9: assert property (@(posedge clk) disable iff (!rstN)
    downEcho |-> (pendingIdx == $past(pendingIdx) - 1'b1));

  assert_cancel_R6: assert property (@(posedge clk) disable iff (!rstN)
    (speedUp && slowDown && !scanStart) |=> $stable(pendingIdx));

  assert_echo_exclusive_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(upEcho && downEcho));

endmodule

// File: rtl/rate_divider.sv
module rate_divider
  import scan_rate_pkg::*;
#(
  parameter int NUM_RATES = 6,
  localparam int IDX_W = $clog2(NUM_RATES),
  localparam int CNT_W = $clog2(NUM_RATES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  divStrobes_t      strobes,
  input  logic [IDX_W-1:0] rateIdx,
  output logic [CNT_W-1:0] ratio,
  output logic             tick
);

  localparam logic [CNT_W-1:0] SLOW_RATIO = CNT_W'(NUM_RATES);

  logic [CNT_W-1:0] phaseCnt;
  logic             lastPhase;

  always_comb begin
    ratio     = SLOW_RATIO - CNT_W'(rateIdx);
    lastPhase = (phaseCnt == ratio - 1'b1);
    tick      = lastPhase;
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      phaseCnt <= '0;
    else if (strobes.restart || lastPhase)
      phaseCnt <= '0;
    else
      phaseCnt <= phaseCnt + 1'b1;
  end

  assert_phase_in_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    phaseCnt < ratio);

  assert_restart_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.restart |=> (phaseCnt == '0));

endmodule

// File: rtl/scan_rate_ctrl.sv
module scan_rate_ctrl
  import scan_rate_pkg::*;
#(
  parameter int NUM_RATES = 6,
  localparam int IDX_W = $clog2(NUM_RATES),
  localparam int CNT_W = $clog2(NUM_RATES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             scanStart,
  input  logic             presetValid,
  input  logic [IDX_W-1:0] presetIdx,
  input  logic             speedUp,
  input  logic             slowDown,
  output logic             shiftTick,
  output logic [IDX_W-1:0] rateIdx,
  output logic [CNT_W-1:0] divRatio,
  output logic             speedUpOut,
  output logic             slowDownOut
);

  divStrobes_t strobes;

  rate_step_ctrl #(.NUM_RATES(NUM_RATES)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .scanStart  (scanStart),
    .presetValid(presetValid),
    .presetIdx  (presetIdx),
    .speedUp    (speedUp),
    .slowDown   (slowDown),
    .tick       (shiftTick),
    .activeIdx  (rateIdx),
    .upEcho     (speedUpOut),
    .downEcho   (slowDownOut),
    .strobes    (strobes)
  );

  rate_divider #(.NUM_RATES(NUM_RATES)) u_div (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .rateIdx(rateIdx),
    .ratio  (divRatio),
    .tick   (shiftTick)
  );

  assert_tick_fast_R2: assert property (@(posedge clk) disable iff (!rstN)
    (divRatio == CNT_W'(1) && !scanStart && $past(divRatio) == CNT_W'(1)) |-> shiftTick);

endmodule

// File: tb/scan_rate_ctrl_tb.sv
module scan_rate_ctrl_tb;

  localparam int NR = 6;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       scanStart = 1'b0;
  logic       presetValid = 1'b0;
  logic [2:0] presetIdx = '0;
  logic       speedUp = 1'b0;
  logic       slowDown = 1'b0;
  logic       shiftTick;
  logic [2:0] rateIdx;
  logic [2:0] divRatio;
  logic       speedUpOut;
  logic       slowDownOut;

  int nTests = 0;
  int nFail  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  scan_rate_ctrl #(.NUM_RATES(NR)) u_dut (
    .clk(clk), .rstN(rstN), .scanStart(scanStart), .presetValid(presetValid),
    .presetIdx(presetIdx), .speedUp(speedUp), .slowDown(slowDown),
    .shiftTick(shiftTick), .rateIdx(rateIdx), .divRatio(divRatio),
    .speedUpOut(speedUpOut), .slowDownOut(slowDownOut)
  );

  task automatic check(input string tag, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic syncTick();
    do @(negedge clk); while (!shiftTick);
  endtask

  task automatic countToTick(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!shiftTick && n < 100);
  endtask

  task automatic testReset();
    check("R1 idx", rateIdx, 0);
    check("R1 ratio", divRatio, NR);
    check("R1 tick", shiftTick, 0);
    check("R1 echo", speedUpOut | slowDownOut, 0);
    @(negedge clk) rstN = 1'b1;
    check("R1 idx after release", rateIdx, 0);
    check("R1 tick after release", shiftTick, 0);
  endtask

  task automatic testDefaultPeriod();
    int n;
    syncTick();
    countToTick(n);
    check("R2 slowest period", n, NR);
  endtask

  task automatic testSpeedStep();
    int n;
    syncTick();
    @(negedge clk) speedUp = 1'b1;
    @(negedge clk) speedUp = 1'b0;
    check("R9 speedUpOut echo", speedUpOut, 1);
    check("R4 idx held mid interval", rateIdx, 0);
    n = 2;
    while (!shiftTick) begin @(negedge clk); n++; end
    check("R4 interval not shortened", n, NR);
    countToTick(n);
    check("R3 faster period", n, NR - 1);
    check("R3 idx raised", rateIdx, 1);
    check("R2 ratio at idx1", divRatio, NR - 1);
  endtask

  task automatic testSaturateUp();
    int n;
    @(negedge clk) speedUp = 1'b1;
    repeat (8) @(negedge clk);
    speedUp = 1'b0;
    syncTick(); syncTick();
    check("R5 idx top", rateIdx, NR - 1);
    check("R2 ratio top", divRatio, 1);
    countToTick(n);
    check("R2 tick every cycle", n, 1);
    @(negedge clk) speedUp = 1'b1;
    @(negedge clk) speedUp = 1'b0;
    check("R9 no echo when saturated", speedUpOut, 0);
    syncTick(); syncTick();
    check("R5 idx stays top", rateIdx, NR - 1);
  endtask

  task automatic testSaturateDown();
    @(negedge clk) slowDown = 1'b1;
    @(negedge clk);
    check("R9 slowDownOut echo", slowDownOut, 1);
    repeat (8) @(negedge clk);
    slowDown = 1'b0;
    syncTick(); syncTick();
    check("R5 idx bottom", rateIdx, 0);
    check("R3 ratio back to slowest", divRatio, NR);
    @(negedge clk) slowDown = 1'b1;
    @(negedge clk) slowDown = 1'b0;
    check("R9 no echo at bottom", slowDownOut, 0);
    syncTick(); syncTick();
    check("R5 idx stays bottom", rateIdx, 0);
  endtask

  task automatic testCancel();
    @(negedge clk) speedUp = 1'b1;
    repeat (2) @(negedge clk);
    speedUp = 1'b0;
    syncTick(); syncTick();
    check("R3 idx two steps", rateIdx, 2);
    @(negedge clk) begin speedUp = 1'b1; slowDown = 1'b1; end
    @(negedge clk) begin speedUp = 1'b0; slowDown = 1'b0; end
    check("R6 no echo on cancel", speedUpOut | slowDownOut, 0);
    syncTick(); syncTick();
    check("R6 idx unchanged", rateIdx, 2);
  endtask

  task automatic testStartDefault();
    int n;
    syncTick();
    @(negedge clk);
    @(negedge clk) scanStart = 1'b1;
    @(negedge clk) scanStart = 1'b0;
    n = 1;
    check("R7 idx slowest", rateIdx, 0);
    check("R7 ratio slowest", divRatio, NR);
    while (!shiftTick) begin @(negedge clk); n++; end
    check("R7 first tick after start", n, NR);
  endtask

  task automatic testStartPreset(input int pre, input int expIdx);
    int n;
    @(negedge clk) begin scanStart = 1'b1; presetValid = 1'b1; presetIdx = 3'(pre); end
    @(negedge clk) begin scanStart = 1'b0; presetValid = 1'b0; end
    n = 1;
    check("R8 preset idx", rateIdx, expIdx);
    check("R8 preset ratio", divRatio, NR - expIdx);
    while (!shiftTick) begin @(negedge clk); n++; end
    check("R8 first tick after preset", n, NR - expIdx);
  endtask

  task automatic testStartOverride();
    @(negedge clk) begin scanStart = 1'b1; presetValid = 1'b1; presetIdx = 3'd2; speedUp = 1'b1; end
    @(negedge clk) begin scanStart = 1'b0; presetValid = 1'b0; speedUp = 1'b0; end
    check("R10 idx from preset", rateIdx, 2);
    check("R10 request not echoed", speedUpOut, 0);
    syncTick(); syncTick();
    check("R10 request dropped", rateIdx, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    testDefaultPeriod();
    testSpeedStep();
    testSaturateUp();
    testSaturateDown();
    testCancel();
    testStartDefault();
    testStartPreset(3, 3);
    testStartPreset(7, NR - 1);
    testStartOverride();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

endmodule